// File: doc/BRIEF.md
# Release-Triggered Serial Byte Sender

This block sends one byte on an asynchronous serial line with one start bit, eight data bits and one stop bit, and no parity. A level request, such as a cleaned-up push button, starts it. Raising the request only arms the sender. The frame goes out once the request falls again. Holding the request for any length of time therefore produces exactly one frame.

The data bits go out most-significant bit first. The byte is captured at the moment of release, so the source may change while the frame is on the line. An internal divider derives the bit period from the system clock. The default is a 50 MHz clock at 9600 bit/s, which gives 5208 clocks per bit. A busy output marks the frame.

Top module: `utx_release_sender`

## Requirements
- R1: While reset is low, and on the first clock after it, `txd` is 1 and `busy` is 0. A reset during a frame abandons the frame.
- R2: Raising `send_req` while idle does not start a frame: `txd` stays 1 and `busy` stays 0 for as long as the request is held high.
- R3: The sender keeps waiting for as long as the request stays high, whatever the hold length.
- R4: On the first clock edge that samples `send_req` low after it was seen high, `busy` goes to 1 and `txd` drives the start bit, which is 0.
- R5: The frame on `txd` is a 0 start bit, then `tx_data` bit 7 down to bit 0, then a 1 stop bit.
- R6: Each frame bit, start and stop included, lasts exactly BIT_CLKS = CLK_HZ/BAUD clock cycles.
- R7: `busy` is high for exactly 10·BIT_CLKS cycles. It then falls, `txd` stays 1, and no further frame follows until there is a new press and release.
- R8: `tx_data` is captured at release. Later changes to `tx_data` do not alter the frame in progress.
- R9: A press and release of `send_req` that starts and ends inside a frame is ignored and produces no second frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | DATA_W | Byte to send, captured at release |
| send_req | input | 1 | Level request; the frame starts when it is released |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | High while a frame is on the line |

## Verification
The bench sends bytes chosen to expose ordering errors. 0xF0 and 0xAC separate most-significant-first from least-significant-first order. 0x01 and 0x80 catch an off-by-one frame index, because each has a single lone one at one edge of the byte. 0x00 and 0xFF show whether the start and stop bits are distinct from the data. Hold lengths run from one cycle to longer than a whole frame, which shows that release, not press, triggers sending. Some frames also carry a press made in the middle of the frame, and every frame has its source byte inverted after release, to test that both are ignored.

// File: rtl/utx_pkg.sv
// Shared types for the release-triggered serial sender.
// Assumes the encodings are private to this block.
package utx_pkg;
    typedef enum logic [1:0] {
        ST_INIT = 2'd0,   // clear frame, line high
        ST_IDLE = 2'd1,   // wait for request high
        ST_HOLD = 2'd2,   // armed, wait for release
        ST_SEND = 2'd3    // shift frame out
    } utx_state_t;
endpackage

// File: rtl/utx_baud.sv
// Bit-period timer: pulses tick once every BIT_CLKS cycles while run is high.
// Assumes BIT_CLKS >= 2. The count restarts at zero whenever run is low,
// so the first bit of a frame gets a full period.
module utx_baud #(
    parameter int BIT_CLKS = 5208
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

    logic [CW-1:0] cnt;

    // Count clocks within the current bit; hold at zero when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + CW'(1);
    end

    assign tick = run && (cnt == LAST);

    // R6: ticks are never back to back
    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/utx_ctrl.sv
// Sequencer: init -> idle -> armed (request held) -> send on release.
// Assumes send_req is already synchronous and free of bounce.
// It steps the frame index from the top position down to 0, once per bit tick.
module utx_ctrl
    import utx_pkg::*;
#(
    parameter int FRAME_W = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       send_req,
    input  logic                       tick,
    output utx_state_t                 state,
    output logic [$clog2(FRAME_W)-1:0] idx,
    output logic                       load
);
    localparam int IW = $clog2(FRAME_W);
    localparam logic [IW-1:0] TOP = IW'(FRAME_W - 1);

    assign load = (state == ST_HOLD) && !send_req;

    // State and index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_INIT;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_INIT: state <= ST_IDLE;
                ST_IDLE: if (send_req) state <= ST_HOLD;
                ST_HOLD: if (load) begin
                    state <= ST_SEND;
                    idx   <= TOP;
                end
                ST_SEND: if (tick) begin
                    if (idx == '0) state <= ST_INIT;
                    else           idx   <= idx - IW'(1);
                end
                default: state <= ST_INIT;
            endcase
        end
    end

    // R3: stays armed while the request is held
    a_r3_hold_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && send_req) |=> (state == ST_HOLD));
    // R4: release starts the frame at the top index
    a_r4_release_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !send_req) |=> (state == ST_SEND && idx == TOP));
    // R6: index steps down by one per bit tick
    a_r6_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && tick && idx != '0) |=> (idx == $past(idx) - IW'(1)));
    // R7: the last bit ends in the init state
    a_r7_frame_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && tick && idx == '0) |=> (state == ST_INIT));
    // R9: the request is ignored during a frame
    a_r9_send_ignores_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && !tick) |=> (state == ST_SEND));
endmodule

// File: rtl/utx_frame.sv
// Frame register: holds {start 0, data, stop 1} and picks the bit at idx.
// Assumes load and clr are never high together.
// Index FRAME_W-1 is the start bit and index 0 is the stop bit, so data leaves MSB first.
module utx_frame #(
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        load,
    input  logic                        send,
    input  logic [DATA_W-1:0]           data,
    input  logic [$clog2(DATA_W+2)-1:0] idx,
    output logic                        txd
);
    localparam int FRAME_W = DATA_W + 2;

    logic [FRAME_W-1:0] frame;

    // Capture the framed byte at release; clear it in init.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) frame <= '0;
        else if (load)     frame <= {1'b0, data, 1'b1};
    end

    // Drive the selected bit while sending, else idle high.
    always_comb begin
        txd = 1'b1;
        if (send) txd = frame[idx];
    end

    // R8: the frame is frozen while sending
    a_r8_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !load && !clr) |=> $stable(frame));
endmodule

// File: rtl/utx_release_sender.sv
// Top: serial byte sender started by the release of a level request.
// Assumes CLK_HZ/BAUD >= 2 and a request that is already free of bounce.
module utx_release_sender
    import utx_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 9600,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              send_req,
    output logic              txd,
    output logic              busy
);
    localparam int BIT_CLKS = CLK_HZ / BAUD;
    localparam int FRAME_W  = DATA_W + 2;
    localparam int IW       = $clog2(FRAME_W);

    utx_state_t    state;
    logic [IW-1:0] idx;
    logic          load;
    logic          tick;

    assign busy = (state == ST_SEND);

    utx_baud #(.BIT_CLKS(BIT_CLKS)) baud_i (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    utx_ctrl #(.FRAME_W(FRAME_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .send_req(send_req), .tick(tick),
        .state(state), .idx(idx), .load(load)
    );

    utx_frame #(.DATA_W(DATA_W)) frame_i (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_INIT), .load(load),
        .send(busy), .data(tx_data), .idx(idx), .txd(txd)
    );

    // R4: a frame always begins with a low start bit
    a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
    // R2: line is high whenever no frame is on it
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
endmodule

// File: tb/utx_release_sender_tb.sv
`timescale 1ns/1ps
module utx_release_sender_tb_top;
    localparam int CLK_HZ = 160;
    localparam int BAUD   = 10;
    localparam int BITC   = CLK_HZ / BAUD;   // 16 clocks per bit

    // vector: data byte, hold cycles, press-during-frame flag
    localparam logic [16:0] VEC [8] = '{
        {8'hF0, 8'd3,   1'b0},
        {8'hAC, 8'd1,   1'b0},
        {8'h00, 8'd10,  1'b1},
        {8'hFF, 8'd5,   1'b0},
        {8'h01, 8'd200, 1'b0},
        {8'h80, 8'd2,   1'b1},
        {8'h5A, 8'd7,   1'b0},
        {8'hA5, 8'd1,   1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       send_req = 1'b0;
    logic       txd;
    logic       busy;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    utx_release_sender #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .send_req(send_req),
        .txd(txd), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input logic [7:0] d, input int hold, input bit mid);
        bit         quiet = 1'b1;
        logic [9:0] bits = '0;
        logic [7:0] got;
        tx_data = d;
        @(negedge clk); send_req = 1'b1;
        for (int c = 0; c < hold; c++) begin
            @(negedge clk);
            if (!(txd == 1'b1 && busy == 1'b0)) quiet = 1'b0;
        end
        check(quiet, "R2/R3 held request sends nothing", int'(quiet), 1);
        send_req = 1'b0;
        @(negedge clk);
        check(busy == 1'b1 && txd == 1'b0, "R4 release starts frame", {busy, txd}, 2);
        tx_data = ~d;   // R8: change source after release
        for (int k = 1; k <= 10 * BITC; k++) begin
            @(negedge clk);
            if (mid && k == 3 * BITC) send_req = 1'b1;     // R9 press mid-frame
            if (mid && k == 3 * BITC + 5) send_req = 1'b0;
            if (k % BITC == BITC / 2) bits[k / BITC] = txd;
            if (k == BITC - 1) check(txd == 1'b0, "R6 start bit length", txd, 0);
            if (k == BITC) check(txd == d[7], "R6 first data bit at period", txd, d[7]);
            if (k == 10 * BITC - 1) check(busy == 1'b1 && txd == 1'b1, "R7 busy through stop", {busy, txd}, 3);
            if (k == 10 * BITC) check(busy == 1'b0 && txd == 1'b1, "R7 busy falls after stop", {busy, txd}, 1);
        end
        for (int b = 0; b < 8; b++) got[7 - b] = bits[1 + b];
        check(bits[0] == 1'b0 && bits[9] == 1'b1, "R5 start/stop framing", {bits[0], bits[9]}, 1);
        check(got == d, "R5 R8 MSB-first data", got, d);
        quiet = 1'b1;
        for (int c = 0; c < 3 * BITC; c++) begin
            @(negedge clk);
            if (!(txd == 1'b1 && busy == 1'b0)) quiet = 1'b0;
        end
        check(quiet, mid ? "R9 mid-frame press ignored" : "R7 single frame", int'(quiet), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(txd == 1'b1 && busy == 1'b0, "R1 in reset", {busy, txd}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1 && busy == 1'b0, "R1 after reset", {busy, txd}, 1);
        repeat (4) @(negedge clk);

        for (int i = 0; i < 8; i++)
            run_frame(VEC[i][16:9], int'(VEC[i][8:1]), VEC[i][0]);

        // R1: reset during a frame abandons it
        tx_data = 8'h3C;
        @(negedge clk); send_req = 1'b1;
        @(negedge clk); send_req = 1'b0;
        repeat (30) @(negedge clk);
        check(busy == 1'b1, "R1 frame in progress before reset", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(txd == 1'b1 && busy == 1'b0, "R1 reset mid-frame", {busy, txd}, 1);
        rst_n = 1'b1;
        repeat (3 * BITC) @(negedge clk);
        check(txd == 1'b1 && busy == 1'b0, "R1 stays idle after reset", {busy, txd}, 1);

        // next frame after reset still works
        run_frame(8'hC3, 4, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule